// File: doc/BRIEF.md
# Redundant-Digit Carry-Save Accumulator

This block keeps a running total as a K-position radix-2 number in which every position holds a digit worth 0, 1 or 2. The total equals the sum of each digit times two to the power of its position. Internally each position is held as two bits, one in a "sum" row and one in a "carry" row, and the digit is their arithmetic sum. On each valid cycle one operation runs. It can add a plain binary operand, add a second redundant operand, fold the total into an ordinary binary word, or do nothing. The additions never propagate a carry further than one position, so their delay does not depend on K.

Digits cross the block edge as two-bit codes, and one select input picks the code for both the operand and the digit readout. In the positional code a digit is written as two times its high bit plus its low bit, and the pattern 11 is illegal. In the thermometer code a digit is the count of ones, so the digit 1 may arrive as 01 or as 10. The fold operation runs the two rows through a ripple-carry chain. It returns the low K bits and a carry flag, and it rewrites the stored total in plain binary form.

The operation select behaves as a four-way mode decoder. The modes are ADD_BIN (code 00), ADD_CS (01), COLLAPSE (10) and RESERVED (11). From any mode the block moves to whichever mode is presented on the next valid cycle. A cycle with valid low is an idle transition and leaves all state unchanged.

Top module: `csa_accum`

## Requirements
- R1: A synchronous active-high reset makes every stored digit 0, bin_o 0, ovf_o 0 and err_o 0 after the clock edge.
- R2: On a cycle with valid_i low, the stored digits, bin_o and ovf_o keep their values and err_o is 0 after the edge.
- R3: When valid_i is high and op_i is 00, bit i of operand_i[K-1:0] is added at position i. With t = digit + bit, the new digit at position i is (t mod 2) plus (t_{i-1} div 2) from the position below. The position-0 term is 0, and the carry out of position K-1 is discarded.
- R4: When valid_i is high and op_i is 01, each operand digit of value v is split into a first row bit (v ≥ 1) and a second row bit (v = 2). The first row is added by the R3 rule, and then the second row is added to that result by the R3 rule, all within one cycle.
- R5: With enc_unary_i at 0, operand digit i is read from operand_i[2i+1:2i] and digits_o[2i+1:2i] carries digit i, with 00 meaning 0, 01 meaning 1 and 10 meaning 2. The code 11 never appears on digits_o.
- R6: With enc_unary_i at 1, operand codes 00, 01, 10 and 11 mean 0, 1, 1 and 2. digits_o writes 0 as 00, 1 as 01 and 2 as 11.
- R7: During an op_i 01 cycle with enc_unary_i at 0, an operand digit coded 11 counts as 0, and err_o is 1 after that edge. In every other cycle err_o is 0 after the edge.
- R8: When valid_i is high and op_i is 10, the stored value V is summed by a ripple chain. After the edge bin_o is V mod 2^K and ovf_o is bit K of V, and every stored digit becomes the matching bit of bin_o.
- R9: When valid_i is high and op_i is 11, the stored digits, bin_o and ovf_o keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Perform the selected operation this cycle |
| op_i | input | 2 | 00 add binary, 01 add carry-save, 10 collapse, 11 reserved |
| enc_unary_i | input | 1 | 0 selects the positional digit code, 1 the thermometer code |
| operand_i | input | 2*K | Carry-save operand as K two-bit codes; low K bits form the binary operand |
| digits_o | output | 2*K | Stored digits in the selected code, digit i at bits 2i+1:2i |
| bin_o | output | K | Binary result of the last collapse |
| ovf_o | output | 1 | Carry out of the last collapse |
| err_o | output | 1 | An illegal operand code was seen in the previous cycle |

## Verification
The bench repeatedly adds all-ones words, which drives digits up to 2 and pushes carries out of the top position. A design that keeps that carry, or that lets a carry move more than one position, shows digit vectors that differ from the model. It sends the thermometer digit 1 in both forms and injects the illegal positional code. A decoder that accepts 11 as 3, or that leaves err_o unset, is caught on the next cycle. Collapses are run on totals above 2^K so that the carry flag and the rewritten digits are exposed. Idle and reserved cycles carry noisy operands to show that a design which leaks them changes its state.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef enum logic [1:0] {
        OP_ADD_BIN  = 2'b00,
        OP_ADD_CS   = 2'b01,
        OP_COLLAPSE = 2'b10,
        OP_RESERVED = 2'b11
    } csa_op_e;

endpackage

// File: rtl/csa_digit_decode.sv
module csa_digit_decode #(
    parameter int K = 8
) (
    input  logic [2*K-1:0] code_i,
    input  logic           unary_i,
    output logic [K-1:0]   row_a_o,
    output logic [K-1:0]   row_b_o,
    output logic           bad_o
);

    logic [K-1:0] bad_vec;

    for (genvar i = 0; i < K; i++) begin : g_dig
        logic hi, lo;
        assign hi = code_i[2*i+1];
        assign lo = code_i[2*i];
        assign bad_vec[i] = !unary_i && hi && lo;
        // row a: digit >= 1, row b: digit == 2
        assign row_a_o[i] = unary_i ? (hi | lo) : ((hi | lo) & ~bad_vec[i]);
        assign row_b_o[i] = unary_i ? (hi & lo) : (hi & ~lo);
    end

    assign bad_o = |bad_vec;

endmodule

// File: rtl/csa_fa_row.sv
module csa_fa_row #(
    parameter int K = 8
) (
    input  logic [K-1:0] s_i,
    input  logic [K-1:0] c_i,
    input  logic [K-1:0] x_i,
    output logic [K-1:0] s_o,
    output logic [K-1:0] c_o
);

    assign c_o[0] = 1'b0;

    for (genvar i = 0; i < K; i++) begin : g_fa
        assign s_o[i] = s_i[i] ^ c_i[i] ^ x_i[i];
        if (i < K - 1) begin : g_up
            assign c_o[i+1] = (s_i[i] & c_i[i]) | (s_i[i] & x_i[i]) | (c_i[i] & x_i[i]);
        end
    end

endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int K = 8
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    output logic [K-1:0] sum_o,
    output logic         cout_o
);

    logic [K:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < K; i++) begin : g_bit
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
        assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = cy[K];

endmodule

// File: rtl/csa_digit_encode.sv
module csa_digit_encode #(
    parameter int K = 8
) (
    input  logic [K-1:0]   s_i,
    input  logic [K-1:0]   c_i,
    input  logic           unary_i,
    output logic [2*K-1:0] code_o
);

    for (genvar i = 0; i < K; i++) begin : g_dig
        logic two, one;
        assign two = s_i[i] & c_i[i];
        assign one = s_i[i] ^ c_i[i];
        assign code_o[2*i+1] = two;
        assign code_o[2*i]   = unary_i ? (one | two) : one;
    end

endmodule

// File: rtl/csa_accum.sv
module csa_accum
    import csa_pkg::*;
#(
    parameter int K = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [1:0]     op_i,
    input  logic           enc_unary_i,
    input  logic [2*K-1:0] operand_i,
    output logic [2*K-1:0] digits_o,
    output logic [K-1:0]   bin_o,
    output logic           ovf_o,
    output logic           err_o
);

    localparam int CW = 2 * K;

    csa_op_e      op;
    logic [K-1:0] s_q, c_q, bin_q;
    logic         ovf_q, err_q;
    logic [K-1:0] s_n, c_n, bin_n;
    logic         ovf_n, err_n;

    logic [K-1:0] row_a, row_b, x1;
    logic         bad;
    logic [K-1:0] s1, c1, s2, c2;
    logic [K-1:0] fold_sum;
    logic         fold_cy;
    logic [CW-1:0] dig_code;

    assign op = csa_op_e'(op_i);

    csa_digit_decode #(.K(K)) u_dec (
        .code_i  (operand_i),
        .unary_i (enc_unary_i),
        .row_a_o (row_a),
        .row_b_o (row_b),
        .bad_o   (bad)
    );

    assign x1 = (op == OP_ADD_CS) ? row_a : operand_i[K-1:0];

    csa_fa_row #(.K(K)) u_row1 (
        .s_i (s_q),
        .c_i (c_q),
        .x_i (x1),
        .s_o (s1),
        .c_o (c1)
    );

    csa_fa_row #(.K(K)) u_row2 (
        .s_i (s1),
        .c_i (c1),
        .x_i (row_b),
        .s_o (s2),
        .c_o (c2)
    );

    csa_ripple #(.K(K)) u_fold (
        .a_i    (s_q),
        .b_i    (c_q),
        .sum_o  (fold_sum),
        .cout_o (fold_cy)
    );

    always_comb begin
        s_n   = s_q;
        c_n   = c_q;
        bin_n = bin_q;
        ovf_n = ovf_q;
        err_n = 1'b0;
        if (valid_i) begin
            unique case (op)
                OP_ADD_BIN: begin
                    s_n = s1;
                    c_n = c1;
                end
                OP_ADD_CS: begin
                    s_n   = s2;
                    c_n   = c2;
                    err_n = bad;
                end
                OP_COLLAPSE: begin
                    s_n   = fold_sum;
                    c_n   = '0;
                    bin_n = fold_sum;
                    ovf_n = fold_cy;
                end
                OP_RESERVED: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q   <= '0;
            c_q   <= '0;
            bin_q <= '0;
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            s_q   <= s_n;
            c_q   <= c_n;
            bin_q <= bin_n;
            ovf_q <= ovf_n;
            err_q <= err_n;
        end
    end

    csa_digit_encode #(.K(K)) u_enc (
        .s_i     (s_q),
        .c_i     (c_q),
        .unary_i (enc_unary_i),
        .code_o  (dig_code)
    );

    assign digits_o = dig_code;
    assign bin_o    = bin_q;
    assign ovf_o    = ovf_q;
    assign err_o    = err_q;

    logic any_eleven;
    always_comb begin
        any_eleven = 1'b0;
        for (int i = 0; i < K; i++) begin
            if (dig_code[2*i+1] && dig_code[2*i]) any_eleven = 1'b1;
        end
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(s_q) && $stable(c_q) && $stable(bin_q) && $stable(ovf_q) && !err_q);

    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == 2'b11 |=> $stable(s_q) && $stable(c_q) && $stable(bin_q) && $stable(ovf_q));

    a_r8_collapse_plain: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == 2'b10 |=> (c_q == '0) && (s_q == bin_q));

    a_r7_err_source: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(valid_i) && $past(op_i) == 2'b01 && !$past(enc_unary_i));

    a_r5_no_code11: assert property (@(posedge clk) disable iff (rst)
        !enc_unary_i |-> !any_eleven);

endmodule

// File: tb/tb_csa_accum.sv
module tb_csa_accum;

    localparam int K = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           valid;
    logic [1:0]     op;
    logic           enc_u;
    logic [2*K-1:0] operand;
    logic [2*K-1:0] digits;
    logic [K-1:0]   bin;
    logic           ovf;
    logic           err;

    csa_accum #(.K(K)) dut (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (valid),
        .op_i        (op),
        .enc_unary_i (enc_u),
        .operand_i   (operand),
        .digits_o    (digits),
        .bin_o       (bin),
        .ovf_o       (ovf),
        .err_o       (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    int           mdig [K];
    logic [K-1:0] mbin;
    logic         movf;
    logic         merr;

    function automatic logic [2*K-1:0] exp_digits(logic unary);
        logic [2*K-1:0] r;
        r = '0;
        for (int i = 0; i < K; i++) begin
            if (mdig[i] == 2)      r[2*i +: 2] = unary ? 2'b11 : 2'b10;
            else if (mdig[i] == 1) r[2*i +: 2] = 2'b01;
        end
        return r;
    endfunction

    task automatic add_row(logic [K-1:0] x);
        int t [K];
        for (int i = 0; i < K; i++) t[i] = mdig[i] + int'(x[i]);
        for (int i = 0; i < K; i++) mdig[i] = (t[i] % 2) + ((i > 0) ? t[i-1] / 2 : 0);
    endtask

    task automatic model_step();
        merr = 1'b0;
        if (rst) begin
            for (int i = 0; i < K; i++) mdig[i] = 0;
            mbin = '0;
            movf = 1'b0;
        end else if (valid) begin
            case (op)
                2'b00: add_row(operand[K-1:0]);
                2'b01: begin
                    logic [K-1:0] ra, rb;
                    for (int i = 0; i < K; i++) begin
                        int v;
                        logic hi, lo;
                        hi = operand[2*i+1];
                        lo = operand[2*i];
                        if (enc_u) v = int'(hi) + int'(lo);
                        else if (hi && lo) begin
                            v = 0;
                            merr = 1'b1;
                        end else v = hi ? 2 : (lo ? 1 : 0);
                        ra[i] = (v >= 1);
                        rb[i] = (v == 2);
                    end
                    add_row(ra);
                    add_row(rb);
                end
                2'b10: begin
                    longint val;
                    val = 0;
                    for (int i = 0; i < K; i++) val += longint'(mdig[i]) << i;
                    for (int i = 0; i < K; i++) mbin[i] = val[i];
                    movf = val[K];
                    for (int i = 0; i < K; i++) mdig[i] = int'(mbin[i]);
                end
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        string dtag;
        dtag = enc_u ? "R6" : "R5";
        check({tag, " ", dtag}, "digits", 64'(digits), 64'(exp_digits(enc_u)));
        check({tag, " R8"}, "bin", 64'(bin), 64'(mbin));
        check({tag, " R8"}, "ovf", 64'(ovf), 64'(movf));
        check({tag, " R7"}, "err", 64'(err), 64'(merr));
    endtask

    task automatic cyc(string tag, logic r, logic v, logic [1:0] o, logic e, logic [2*K-1:0] d);
        rst = r;
        valid = v;
        op = o;
        enc_u = e;
        operand = d;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        rst = 1'b1;
        valid = 1'b0;
        op = 2'b00;
        enc_u = 1'b0;
        operand = '0;
        for (int i = 0; i < K; i++) mdig[i] = 0;
        mbin = '0;
        movf = 1'b0;
        merr = 1'b0;
        @(negedge clk);

        // R1: reset state
        cyc("R1", 1'b1, 1'b0, 2'b00, 1'b0, '0);
        check("R1", "digits zero", 64'(digits), 64'd0);
        check("R1", "bin zero", 64'(bin), 64'd0);

        // R3: binary adds, repeated all-ones pushes carries off the top
        cyc("R3", 1'b0, 1'b1, 2'b00, 1'b0, 16'h00A5);
        cyc("R3", 1'b0, 1'b1, 2'b00, 1'b0, 16'h00FF);
        cyc("R3", 1'b0, 1'b1, 2'b00, 1'b0, 16'h00FF);
        cyc("R3", 1'b0, 1'b1, 2'b00, 1'b0, 16'h0081);

        // R2: idle cycles with noisy operands
        cyc("R2", 1'b0, 1'b0, 2'b00, 1'b0, 16'hFFFF);
        cyc("R2", 1'b0, 1'b0, 2'b10, 1'b1, 16'h5A5A);

        // R8: collapse of a total that exceeds 2^K
        cyc("R8", 1'b0, 1'b1, 2'b10, 1'b0, 16'h1234);

        // R4/R5: carry-save add with positional codes (2,1,0 mixes)
        cyc("R4", 1'b0, 1'b1, 2'b01, 1'b0, 16'b10_01_00_10_10_01_01_10);
        cyc("R4", 1'b0, 1'b1, 2'b01, 1'b0, 16'b10_10_10_10_10_10_10_10);

        // R6: thermometer code, digit 1 as 01 and as 10
        cyc("R6", 1'b0, 1'b1, 2'b01, 1'b1, 16'b01_01_01_01_00_00_11_11);
        cyc("R6", 1'b0, 1'b1, 2'b01, 1'b1, 16'b10_10_10_10_00_00_11_11);

        // R7: illegal positional code 11 counts as zero and flags
        cyc("R7", 1'b0, 1'b1, 2'b01, 1'b0, 16'b11_00_01_00_11_10_00_01);
        cyc("R7", 1'b0, 1'b1, 2'b01, 1'b1, 16'b11_11_11_11_11_11_11_11);
        cyc("R7", 1'b0, 1'b1, 2'b00, 1'b0, 16'hFFFF);

        // R9: reserved op leaves state alone
        cyc("R9", 1'b0, 1'b1, 2'b11, 1'b0, 16'hFFFF);
        cyc("R8", 1'b0, 1'b1, 2'b10, 1'b1, 16'h0000);
        cyc("R9", 1'b0, 1'b1, 2'b11, 1'b1, 16'hAAAA);

        // mixed traffic
        seed = 32'h2468ACE1;
        for (int n = 0; n < 400; n++) begin
            logic [2*K-1:0] d;
            logic v, e;
            logic [1:0] o;
            seed = seed * 1103515245 + 12345;
            d = seed[31:16];
            seed = seed * 1103515245 + 12345;
            v = (seed[20:18] != 3'd0);
            o = seed[23:22];
            e = seed[25];
            cyc("R3 R4 mix", 1'b0, v, o, e, d);
        end

        // R1: reset in the middle of activity
        cyc("R1", 1'b1, 1'b1, 2'b00, 1'b0, 16'h00FF);
        cyc("R1", 1'b0, 1'b0, 2'b00, 1'b0, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule